// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Controller

This controller sits between a simple host port and an asynchronous DRAM whose row and column addresses share one set of address pins. The host presents a full word address, a write flag and write data, raises a request, and holds it until a one-cycle completion pulse comes back. For reads, the returned data is valid in the same cycle as that pulse. The controller splits the address into a row half and a column half and places each half on the shared pins in turn. It then drives the row strobe low and, after a programmed row-to-column delay, the column strobe. Every access and every refresh ends with both strobes high for a programmed precharge time.

A free-running interval timer schedules refresh. Each refresh is a row-strobe-only cycle that uses an internal row counter, which advances by one per refresh. A refresh that becomes due during a host access waits until that access and its precharge have finished. It then wins over any waiting host request. All delays are counted in controller clock cycles and set by parameters, so one netlist can serve memories with different speed grades.

Top module: `adram_ctrl`

## Requirements
- R1: The host address splits with its upper ROW_W bits as the row and its lower COL_W bits as the column. Each half is placed right-aligned on `dram_addr`, and unused upper pins are driven with zero.
- R2: The row address is on `dram_addr` for at least one cycle before `dram_ras_n` falls, and it is unchanged in the cycle of the fall.
- R3: `dram_cas_n` falls exactly T_RCD cycles after `dram_ras_n` falls, and only while `dram_ras_n` is low. The column address is on the pins for at least one cycle before that fall and is unchanged at it.
- R4: `dram_cas_n` stays low for exactly T_CAS cycles. A read captures `dram_dq_in` at the clock edge that ends the last of those cycles.
- R5: On a write, `dram_we_n` is low (active) and `dram_dq_oe` is high with `dram_dq_out` equal to the host write data. This holds from one cycle before the column strobe falls until it rises. On a read, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R6: Before every fall of `dram_ras_n`, including the first one after reset, both strobes have been high for at least T_RP cycles.
- R7: Refresh comes due every REF_INTERVAL cycles. A refresh holds `dram_ras_n` low for exactly T_RFC cycles while `dram_cas_n` stays high.
- R8: Each refresh row on the pins is the previous refresh row plus one, wrapping modulo 2^ROW_W.
- R9: A due refresh is served after the access in progress and before the next host request is accepted. Even under back-to-back host traffic, two refreshes are never more than REF_INTERVAL plus one access-plus-refresh length apart.
- R10: `done` is high for exactly one cycle per access. For a read, `rd_data` in that cycle holds the word last written to that address. A write leaves `rd_data` unchanged.
- R11: While reset is asserted, both strobes and `dram_we_n` are high, and `dram_dq_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid with `done` |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Assertions check the pin rules on every cycle, whatever the traffic:
- the column strobe only ever falls while the row strobe is low, and exactly T_RCD cycles after the row strobe fell;
- the address pins are steady across each strobe fall;
- the write drivers are active only under the row strobe;
- the precharge gap before each row strobe is respected;
- `done` never lasts two cycles.

Other behaviour only shows up in the bench's scenarios, which run a memory model and a host scoreboard:
- that the right row and column halves reach the pins;
- that read data matches earlier writes;
- that refresh rows count up;
- that refreshes keep their spacing under back-to-back traffic.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ROW_SET = 3'd1,
    ST_RAS     = 3'd2,
    ST_COL_SET = 3'd3,
    ST_CAS     = 3'd4,
    ST_REF_SET = 3'd5,
    ST_REF_RAS = 3'd6,
    ST_PRE     = 3'd7
  } seq_state_t;

endpackage

// File: rtl/adram_refresh_timer.sv
module adram_refresh_timer #(
  parameter int REF_INTERVAL = 780,
  parameter int ROW_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CNT_W = $clog2(REF_INTERVAL + 1);

  logic [CNT_W-1:0] tick_cnt_q, tick_cnt_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  always_comb begin
    tick       = (tick_cnt_q == '0);
    tick_cnt_d = tick ? CNT_W'(REF_INTERVAL - 1) : tick_cnt_q - 1'b1;
    if (tick)         pend_d = 1'b1;
    else if (ref_ack) pend_d = 1'b0;
    else              pend_d = pend_q;
    row_d = ref_ack ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt_q <= CNT_W'(REF_INTERVAL - 1);
      pend_q     <= 1'b0;
      row_q      <= '0;
    end else begin
      tick_cnt_q <= tick_cnt_d;
      pend_q     <= pend_d;
      if (ref_ack) row_q <= row_d;
    end
  end

  assign ref_pend = pend_q;
  assign ref_row  = row_q;

endmodule

// File: rtl/adram_addr_mux.sv
module adram_addr_mux #(
  parameter int ROW_W = 10,
  parameter int COL_W = 9
) (
  input  logic [ROW_W+COL_W-1:0]                     host_addr,
  input  logic [ROW_W-1:0]                           ref_row,
  input  logic                                       sel_col,
  input  logic                                       sel_ref,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] pin_addr
);

  localparam int ADDR_W = ROW_W + COL_W;

  always_comb begin
    pin_addr = '0;
    if (sel_ref)
      pin_addr[ROW_W-1:0] = ref_row;
    else if (sel_col)
      pin_addr[COL_W-1:0] = host_addr[COL_W-1:0];
    else
      pin_addr[ROW_W-1:0] = host_addr[ADDR_W-1:COL_W];
  end

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2,
  parameter int T_RFC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ref_pend,
  output logic accept,
  output logic ref_ack,
  output logic ras_n,
  output logic cas_n,
  output logic col_phase,
  output logic ref_phase,
  output logic cas_last
);

  localparam int MAX_A  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int MAX_B  = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WAIT_W = $clog2(MAX_T + 1);

  seq_state_t        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              wait_zero;

  assign wait_zero = (wait_q == '0);

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_zero ? wait_q : wait_q - 1'b1;
    accept   = 1'b0;
    ref_ack  = 1'b0;
    cas_last = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_ack = 1'b1;
          state_d = ST_REF_SET;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ROW_SET;
        end
      end
      ST_ROW_SET: begin
        state_d = ST_RAS;
        wait_d  = WAIT_W'(T_RCD - 2);
      end
      ST_RAS: begin
        if (wait_zero) state_d = ST_COL_SET;
      end
      ST_COL_SET: begin
        state_d = ST_CAS;
        wait_d  = WAIT_W'(T_CAS - 1);
      end
      ST_CAS: begin
        if (wait_zero) begin
          cas_last = 1'b1;
          state_d  = ST_PRE;
          wait_d   = WAIT_W'(T_RP - 1);
        end
      end
      ST_REF_SET: begin
        state_d = ST_REF_RAS;
        wait_d  = WAIT_W'(T_RFC - 1);
      end
      ST_REF_RAS: begin
        if (wait_zero) begin
          state_d = ST_PRE;
          wait_d  = WAIT_W'(T_RP - 1);
        end
      end
      ST_PRE: begin
        if (wait_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRE;
      wait_q  <= WAIT_W'(T_RP - 1);
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  always_comb begin
    ras_n     = !(state_q inside {ST_RAS, ST_COL_SET, ST_CAS, ST_REF_RAS});
    cas_n     = (state_q != ST_CAS);
    col_phase = (state_q inside {ST_COL_SET, ST_CAS});
    ref_phase = (state_q inside {ST_REF_SET, ST_REF_RAS});
  end

endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 4,
  parameter int REF_INTERVAL = 780
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  input  logic                                         req_write,
  input  logic [ROW_W+COL_W-1:0]                       req_addr,
  input  logic [DATA_W-1:0]                            req_wdata,
  output logic                                         done,
  output logic [DATA_W-1:0]                            rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                         dram_ras_n,
  output logic                                         dram_cas_n,
  output logic                                         dram_we_n,
  output logic [DATA_W-1:0]                            dram_dq_out,
  output logic                                         dram_dq_oe,
  input  logic [DATA_W-1:0]                            dram_dq_in
);

  localparam int ADDR_W = ROW_W + COL_W;

  logic              accept, ref_ack, ref_pend;
  logic              col_phase, ref_phase, cas_last;
  logic [ROW_W-1:0]  ref_row;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic              done_q;

  adram_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .ROW_W       (ROW_W)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_ack (ref_ack),
    .ref_pend(ref_pend),
    .ref_row (ref_row)
  );

  adram_seq #(
    .T_RCD(T_RCD),
    .T_CAS(T_CAS),
    .T_RP (T_RP),
    .T_RFC(T_RFC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .ref_pend (ref_pend),
    .accept   (accept),
    .ref_ack  (ref_ack),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .col_phase(col_phase),
    .ref_phase(ref_phase),
    .cas_last (cas_last)
  );

  adram_addr_mux #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_mux (
    .host_addr(addr_q),
    .ref_row  (ref_row),
    .sel_col  (col_phase),
    .sel_ref  (ref_phase),
    .pin_addr (dram_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (cas_last && !wr_q) rd_q <= dram_dq_in;
      done_q <= cas_last;
    end
  end

  assign dram_we_n   = !(wr_q && col_phase);
  assign dram_dq_oe  = wr_q && col_phase;
  assign dram_dq_out = wdata_q;
  assign done        = done_q;
  assign rd_data     = rd_q;

endmodule

// File: rtl/adram_ctrl_chk.sv
module adram_ctrl_chk #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int PIN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic             done,
  input logic [PIN_W-1:0] pin_addr
);

  localparam int LIM = (T_RCD > T_RP) ? T_RCD + 1 : T_RP + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (!ras_n)                    hi_cnt <= '0;
      else if (hi_cnt != CW'(LIM))   hi_cnt <= hi_cnt + 1'b1;
      if (ras_n)                     lo_cnt <= '0;
      else if (lo_cnt != CW'(LIM))   lo_cnt <= lo_cnt + 1'b1;
    end
  end

  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(pin_addr));

  a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r3_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(pin_addr));

  a_r3_rcd_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (lo_cnt == CW'(T_RCD)));

  a_r5_write_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || dq_oe) |-> !ras_n);

  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= CW'(T_RP)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind adram_ctrl adram_ctrl_chk #(
  .T_RCD(T_RCD),
  .T_RP (T_RP),
  .PIN_W((ROW_W > COL_W) ? ROW_W : COL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ras_n   (dram_ras_n),
  .cas_n   (dram_cas_n),
  .we_n    (dram_we_n),
  .dq_oe   (dram_dq_oe),
  .done    (done),
  .pin_addr(dram_addr)
);

// File: tb/sim_adram_ctrl.sv
`timescale 1ns/1ps
module sim_adram_ctrl;

  localparam int ROW_W  = 7;
  localparam int COL_W  = 5;
  localparam int DATA_W = 16;
  localparam int T_RCD  = 3;
  localparam int T_CAS  = 2;
  localparam int T_RP   = 2;
  localparam int T_RFC  = 4;
  localparam int T_REF  = 120;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int SLACK  = T_RCD + T_CAS + T_RP + T_RFC + 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              done;
  logic [DATA_W-1:0] rd_data;
  logic [PIN_W-1:0]  dram_addr;
  logic              dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] dram_dq_out;
  logic [DATA_W-1:0] dram_dq_in = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ref_seen = 0;

  logic [DATA_W-1:0] model_mem [int];
  logic [DATA_W-1:0] exp_mem   [int];
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [DATA_W-1:0] cur_wdata = '0;
  logic              cur_write = 1'b0;

  always #2.5 clk = ~clk;

  adram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFC(T_RFC),
    .REF_INTERVAL(T_REF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] model_read(input int a);
    if (model_mem.exists(a)) return model_mem[a];
    return '0;
  endfunction

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  // Pin monitor and memory model
  logic             prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [PIN_W-1:0] prev_addr = '0;
  logic [ROW_W-1:0] cur_row = '0, last_ref_row = '0;
  int  ras_lo = 0, cas_lo = 0, ras_hi = 0, ref_gap = 0;
  bit  saw_cas = 1'b0, have_ref = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R11 reset state
      check(dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe && !done,
            "R11", {27'd0, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, done}, 32'h1c);
      ras_hi = 0;
    end else begin
      ref_gap++;
      if (prev_ras && !dram_ras_n) begin
        check(dram_addr == prev_addr, "R2", 32'(dram_addr), 32'(prev_addr));
        check(ras_hi >= T_RP, "R6", ras_hi, T_RP);
        cur_row = dram_addr[ROW_W-1:0];
        saw_cas = 1'b0;
        ras_lo  = 0;
      end
      if (prev_cas && !dram_cas_n) begin
        int a;
        check(ras_lo == T_RCD, "R3", ras_lo, T_RCD);
        check(dram_addr == prev_addr, "R3", 32'(dram_addr), 32'(prev_addr));
        check({cur_row, dram_addr[COL_W-1:0]} == cur_addr && dram_addr[PIN_W-1:COL_W] == '0,
              "R1", 32'({cur_row, dram_addr[COL_W-1:0]}), 32'(cur_addr));
        check(prev_we == !cur_write, "R5", 32'(prev_we), 32'(!cur_write));
        a = int'({cur_row, dram_addr[COL_W-1:0]});
        if (cur_write) begin
          check(!dram_we_n && dram_dq_oe && dram_dq_out == cur_wdata, "R5",
                32'(dram_dq_out), 32'(cur_wdata));
          model_mem[a] = dram_dq_out;
        end else begin
          check(dram_we_n && !dram_dq_oe, "R5", {30'd0, dram_we_n, dram_dq_oe}, 32'h2);
        end
        dram_dq_in = model_read(a);
        saw_cas = 1'b1;
        cas_lo  = 0;
      end
      if (!prev_cas && dram_cas_n) check(cas_lo == T_CAS, "R4", cas_lo, T_CAS);
      if (!dram_cas_n && dram_ras_n) check(1'b0, "R3", 32'd1, 32'd0);
      if (!prev_ras && dram_ras_n && !saw_cas) begin
        check(ras_lo == T_RFC, "R7", ras_lo, T_RFC);
        if (have_ref)
          check(cur_row == next_row(last_ref_row), "R8", 32'(cur_row), 32'(next_row(last_ref_row)));
        check(ref_gap <= T_REF + SLACK && (!have_ref || ref_gap >= T_REF - SLACK),
              "R9", ref_gap, T_REF);
        last_ref_row = cur_row;
        have_ref = 1'b1;
        ref_gap  = 0;
        ref_seen++;
      end
      if (!dram_ras_n) begin ras_lo++; ras_hi = 0; end else ras_hi++;
      if (!dram_cas_n) cas_lo++;
      prev_ras  = dram_ras_n;
      prev_cas  = dram_cas_n;
      prev_we   = dram_we_n;
      prev_addr = dram_addr;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] old_rd;
    old_rd    = rd_data;
    cur_addr  = a;
    cur_wdata = d;
    cur_write = wr;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      exp_mem[int'(a)] = d;
      check(rd_data == old_rd, "R10", 32'(rd_data), 32'(old_rd));
    end else begin
      check(rd_data == exp_read(a), "R10", 32'(rd_data), 32'(exp_read(a)));
    end
    @(negedge clk);
    check(!done, "R10", 32'(done), 32'd0);
  endtask

  function automatic logic [ADDR_W-1:0] pick_addr();
    logic [ROW_W-1:0] r;
    logic [COL_W-1:0] c;
    case ($urandom % 4)
      0: r = '0; 1: r = '1; 2: r = ROW_W'(5); default: r = ROW_W'($urandom);
    endcase
    case ($urandom % 4)
      0: c = '0; 1: c = '1; 2: c = COL_W'(9); default: c = COL_W'($urandom);
    endcase
    return {r, c};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: extreme addresses, row/column distinguishable
    access(1'b1, '1, 16'hbeef);
    access(1'b1, '0, 16'h1234);
    access(1'b1, {ROW_W'(1), COL_W'(0)}, 16'h00a5);
    access(1'b1, {ROW_W'(0), COL_W'(1)}, 16'h5a00);
    access(1'b0, '1, '0);
    access(1'b0, '0, '0);
    access(1'b0, {ROW_W'(1), COL_W'(0)}, '0);
    access(1'b0, {ROW_W'(0), COL_W'(1)}, '0);

    // Back-to-back traffic across several refresh intervals (R9)
    for (int i = 0; i < 80; i++)
      access($urandom % 2 == 1, pick_addr(), DATA_W'($urandom));

    // Random traffic with idle gaps
    for (int i = 0; i < 120; i++) begin
      repeat ($urandom % 12) @(negedge clk);
      access($urandom % 3 != 0, pick_addr(), DATA_W'($urandom));
    end

    // Long idle: refreshes alone (R7, R8)
    repeat (6 * T_REF) @(negedge clk);
    check(ref_seen >= 10, "R7", ref_seen, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule